// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block sits beside a DDR SDRAM command arbiter. It keeps the memory refreshed. A free-running interval timer counts controller clocks against a programmable limit. Each time the limit is reached, one more refresh is owed. The owed count is held in a saturating backlog of at most `MAX_PEND` entries. While the backlog is non-zero, the block asks the arbiter for the bus and asks for all banks to be precharged. When the backlog is full, it also raises an urgency flag so that the arbiter lets the refresh win.

When the arbiter grants the bus and reports every bank idle in the same cycle, the block drives one AUTO REFRESH command. It then keeps the bus blocked until the refresh cycle time has passed. The same handshake brings the memory into self-refresh on request. The entry command has the refresh pattern with CKE dropping low, and CKE stays low until the request is withdrawn. On exit, two separate windows are enforced. A shorter one applies to all non-read commands and a longer one applies to reads. Self-refresh is also the only time the controller may change its clock frequency.

The control state machine has nine states:
- `ST_IDLE`: nothing owed.
- `ST_REQ`: refresh requested.
- `ST_AREF`: refresh command cycle.
- `ST_TRFC`: refresh recovery.
- `ST_SRPRE`: self-refresh requested.
- `ST_SRENT`: entry command cycle.
- `ST_SELF`: in self-refresh.
- `ST_XNR`: exit, everything blocked.
- `ST_XRD`: exit, reads blocked.

The transitions are:
- `ST_IDLE` to `ST_SRPRE` on a self-refresh request, otherwise to `ST_REQ` when the backlog is non-zero.
- `ST_REQ` to `ST_SRPRE` on a self-refresh request, otherwise to `ST_AREF` on grant with all banks idle.
- `ST_AREF` to `ST_TRFC`.
- `ST_TRFC` to `ST_IDLE` when its timer expires.
- `ST_SRPRE` to `ST_SRENT` on grant with all banks idle, or back to `ST_IDLE` if the request is withdrawn.
- `ST_SRENT` to `ST_SELF`.
- `ST_SELF` to `ST_XNR` when the request falls.
- `ST_XNR` to `ST_XRD` when its timer expires.
- `ST_XRD` to `ST_IDLE` when its timer expires.

Top module: `refresh_sched`

## Requirements
- R1: The interval timer produces one tick every `refi_limit_i` clocks. Each tick raises `pending_o` by exactly one.
- R2: `pending_o` never exceeds `MAX_PEND` (8) and holds at 8 when further ticks arrive. `ref_urgent_o` is 1 exactly when `pending_o` equals 8.
- R3: While `pending_o` is non-zero outside the self-refresh flow, `ref_req_o` and `pre_all_o` are 1. No command is issued unless `ref_gnt_i` and `all_idle_i` were both 1 in the preceding cycle.
- R4: An AUTO REFRESH lasts one cycle with `cmd_valid_o`=1 and {cs_n,ras_n,cas_n,we_n}=4'b0001. CKE is 1 in that cycle and the one before. `pending_o` drops by one afterwards.
- R5: `bus_free_o` is 0 for exactly `RFC_CYC` cycles, counting from the refresh command cycle.
- R6: Self-refresh entry drives the same command pattern with `cke_o`=0 in the command cycle. `cke_o` stays 0 and `sr_active_o` is 1 while `sr_req_i` stays high. The backlog is cleared on entry, and interval ticks are ignored while in self-refresh.
- R7: After `sr_req_i` falls, `cke_o` returns to 1 in the next cycle. `bus_free_o` stays 0 for `RFC_CYC`+1 cycles, counting from that cycle.
- R8: `read_ok_o` stays 0 for `XSRD_CYC` cycles, counting from the cycle in which CKE rises. `read_ok_o`=1 always implies `bus_free_o`=1.
- R9: After reset, `cke_o`=1, `pending_o`=0, `ref_req_o`=0, `bus_free_o`=1, `read_ok_o`=1, and the command pins are all 1.
- R10: A self-refresh request takes priority over a pending AUTO REFRESH. From `ST_REQ`, a request moves the block to the self-refresh handshake, still asking for precharge-all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | controller clock |
| rst_n | input | 1 | active-low synchronous reset |
| refi_limit_i | input | REFI_W | refresh interval in clocks |
| sr_req_i | input | 1 | level request to stay in self-refresh |
| ref_gnt_i | input | 1 | arbiter grant of the command bus |
| all_idle_i | input | 1 | all banks are precharged |
| ref_req_o | output | 1 | bus request to the arbiter |
| ref_urgent_o | output | 1 | backlog full, request must win |
| pre_all_o | output | 1 | asks the controller to precharge all banks |
| cmd_valid_o | output | 1 | a command is driven this cycle |
| cs_n_o | output | 1 | chip select, active low |
| ras_n_o | output | 1 | row strobe, active low |
| cas_n_o | output | 1 | column strobe, active low |
| we_n_o | output | 1 | write enable, active low |
| cke_o | output | 1 | clock enable to the memory |
| bus_free_o | output | 1 | non-read commands may be issued |
| read_ok_o | output | 1 | read commands may be issued |
| sr_active_o | output | 1 | in self-refresh, clock may change |
| pending_o | output | PEND_W | postponed refresh count |

## Verification
The hardest condition to reach is a full backlog of eight postponed refreshes with the urgency flag raised. This only happens if the arbiter refuses the bus for eight whole intervals. The bench therefore keeps the grant low, lets the counter climb through 7 to 8, and holds it there for further intervals to show saturation. It then switches the interval to a large value and grants repeatedly, so the backlog drains with a known number of commands. Reaching self-refresh exit also needs a preceding granted entry. For that, the request is raised while a refresh is already owed, which covers the priority case as well.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_REQ   = 4'd1,
        ST_AREF  = 4'd2,
        ST_TRFC  = 4'd3,
        ST_SRPRE = 4'd4,
        ST_SRENT = 4'd5,
        ST_SELF  = 4'd6,
        ST_XNR   = 4'd7,
        ST_XRD   = 4'd8
    } rs_state_t;

    // command pin bundle {cs_n, ras_n, cas_n, we_n}
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PINS_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t PINS_REF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/refi_timer.sv
module refi_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] limit_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    // the limit may shrink while counting; >= keeps the wrap bounded
    assign last   = ({1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, limit_i};
    assign tick_o = last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
    parameter int MAX_PEND = 8,
    parameter int PEND_W   = $clog2(MAX_PEND + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              dec_i,
    input  logic              clr_i,
    output logic [PEND_W-1:0] pend_o,
    output logic              full_o
);
    localparam logic [PEND_W-1:0] TOP = PEND_W'(MAX_PEND);

    logic [PEND_W-1:0] pend_q;

    assign pend_o = pend_q;
    assign full_o = (pend_q == TOP);

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            pend_q <= '0;
        end else if (inc_i && !dec_i) begin
            if (pend_q != TOP) begin
                pend_q <= pend_q + 1'b1;
            end
        end else if (dec_i && !inc_i) begin
            if (pend_q != '0) begin
                pend_q <= pend_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    assign zero_o = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refsch_pkg::*;
#(
    parameter int REFI_W   = 16,
    parameter int RFC_CYC  = 14,
    parameter int XSRD_CYC = 200,
    parameter int MAX_PEND = 8,
    localparam int PEND_W  = $clog2(MAX_PEND + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REFI_W-1:0] refi_limit_i,
    input  logic              sr_req_i,
    input  logic              ref_gnt_i,
    input  logic              all_idle_i,
    output logic              ref_req_o,
    output logic              ref_urgent_o,
    output logic              pre_all_o,
    output logic              cmd_valid_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic              cke_o,
    output logic              bus_free_o,
    output logic              read_ok_o,
    output logic              sr_active_o,
    output logic [PEND_W-1:0] pending_o
);
    localparam int XSNR_CYC = RFC_CYC + 1;
    localparam int TMR_W    = $clog2(XSRD_CYC + 1);

    // each load value is the length of the next state minus one
    localparam logic [TMR_W-1:0] LD_TRFC = TMR_W'(RFC_CYC - 2);
    localparam logic [TMR_W-1:0] LD_XNR  = TMR_W'(XSNR_CYC - 1);
    localparam logic [TMR_W-1:0] LD_XRD  = TMR_W'(XSRD_CYC - XSNR_CYC - 1);

    rs_state_t         state_q, state_d;
    logic              tick;
    logic              bl_inc, bl_dec, bl_clr, bl_full;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              grant_ok;
    cmd_pins_t         pins;

    assign grant_ok = ref_gnt_i && all_idle_i;

    refi_timer #(.CNT_W(REFI_W)) u_refi (
        .clk     (clk),
        .rst_n   (rst_n),
        .limit_i (refi_limit_i),
        .tick_o  (tick)
    );

    // ticks are dropped while the device refreshes itself
    assign bl_inc = tick && (state_q != ST_SRENT) && (state_q != ST_SELF);
    assign bl_dec = (state_q == ST_AREF);
    assign bl_clr = (state_q == ST_SRENT);

    refresh_backlog #(.MAX_PEND(MAX_PEND), .PEND_W(PEND_W)) u_backlog (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (bl_inc),
        .dec_i  (bl_dec),
        .clr_i  (bl_clr),
        .pend_o (pending_o),
        .full_o (bl_full)
    );

    wait_timer #(.CNT_W(TMR_W)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (sr_req_i) begin
                    state_d = ST_SRPRE;
                end else if (pending_o != '0) begin
                    state_d = ST_REQ;
                end
            end
            ST_REQ: begin
                if (sr_req_i) begin
                    state_d = ST_SRPRE;
                end else if (grant_ok) begin
                    state_d = ST_AREF;
                end
            end
            ST_AREF: begin
                state_d  = ST_TRFC;
                tmr_load = 1'b1;
                tmr_val  = LD_TRFC;
            end
            ST_TRFC: begin
                if (tmr_zero) begin
                    state_d = ST_IDLE;
                end
            end
            ST_SRPRE: begin
                if (!sr_req_i) begin
                    state_d = ST_IDLE;
                end else if (grant_ok) begin
                    state_d = ST_SRENT;
                end
            end
            ST_SRENT: begin
                state_d = ST_SELF;
            end
            ST_SELF: begin
                if (!sr_req_i) begin
                    state_d  = ST_XNR;
                    tmr_load = 1'b1;
                    tmr_val  = LD_XNR;
                end
            end
            ST_XNR: begin
                if (tmr_zero) begin
                    state_d  = ST_XRD;
                    tmr_load = 1'b1;
                    tmr_val  = LD_XRD;
                end
            end
            ST_XRD: begin
                if (tmr_zero) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        ref_req_o   = 1'b0;
        pre_all_o   = 1'b0;
        cmd_valid_o = 1'b0;
        pins        = PINS_DESEL;
        cke_o       = 1'b1;
        bus_free_o  = 1'b1;
        read_ok_o   = 1'b1;
        sr_active_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_REQ, ST_SRPRE: begin
                ref_req_o = 1'b1;
                pre_all_o = 1'b1;
            end
            ST_AREF: begin
                cmd_valid_o = 1'b1;
                pins        = PINS_REF;
                bus_free_o  = 1'b0;
                read_ok_o   = 1'b0;
            end
            ST_TRFC, ST_XNR: begin
                bus_free_o = 1'b0;
                read_ok_o  = 1'b0;
            end
            ST_SRENT: begin
                cmd_valid_o = 1'b1;
                pins        = PINS_REF;
                cke_o       = 1'b0;
                bus_free_o  = 1'b0;
                read_ok_o   = 1'b0;
            end
            ST_SELF: begin
                cke_o       = 1'b0;
                sr_active_o = 1'b1;
                bus_free_o  = 1'b0;
                read_ok_o   = 1'b0;
            end
            ST_XRD: begin
                read_ok_o = 1'b0;
            end
            default: begin
            end
        endcase
    end

    assign ref_urgent_o = bl_full;
    assign cs_n_o       = pins.cs_n;
    assign ras_n_o      = pins.ras_n;
    assign cas_n_o      = pins.cas_n;
    assign we_n_o       = pins.we_n;

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int MAX_PEND = 8,
    parameter int PEND_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_gnt_i,
    input logic              all_idle_i,
    input logic              cmd_valid_o,
    input logic              cke_o,
    input logic              bus_free_o,
    input logic              read_ok_o,
    input logic              sr_active_o,
    input logic [PEND_W-1:0] pending_o
);
    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o <= PEND_W'(MAX_PEND));  // R2

    AST_PEND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o > $past(pending_o)) |-> (pending_o == $past(pending_o) + PEND_W'(1)));  // R1

    AST_CMD_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> $past(ref_gnt_i && all_idle_i));  // R3

    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);  // R4

    AST_HOLD_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cke_o) |=> !bus_free_o);  // R5

    AST_SR_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active_o |-> !cke_o);  // R6

    AST_EXIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> (!bus_free_o && !read_ok_o));  // R7

    AST_READ_IMPLIES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        read_ok_o |-> bus_free_o);  // R8
endmodule

bind refresh_sched refresh_sched_chk #(.MAX_PEND(MAX_PEND), .PEND_W(PEND_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_gnt_i   (ref_gnt_i),
    .all_idle_i  (all_idle_i),
    .cmd_valid_o (cmd_valid_o),
    .cke_o       (cke_o),
    .bus_free_o  (bus_free_o),
    .read_ok_o   (read_ok_o),
    .sr_active_o (sr_active_o),
    .pending_o   (pending_o)
);

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
    localparam int CLK_PER  = 10;
    localparam int RFC      = 4;
    localparam int XSRD     = 20;
    localparam int MAXP     = 8;
    localparam int EXP_AR   = 1;
    localparam int EXP_SRE  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] refi_limit = 16'd50;
    logic        sr_req = 1'b0;
    logic        gnt = 1'b0;
    logic        idle = 1'b0;
    logic        ref_req, urgent, pre_all, cmd_valid;
    logic        cs_n, ras_n, cas_n, we_n, cke, bus_free, read_ok, sr_active;
    logic [3:0]  pending;

    int n_run  = 0;
    int n_fail = 0;
    int n_cmd  = 0;
    bit done   = 1'b0;
    int exp_q[$];
    logic prev_cke = 1'b1;

    always #(CLK_PER/2) clk = ~clk;

    refresh_sched #(
        .REFI_W(16), .RFC_CYC(RFC), .XSRD_CYC(XSRD), .MAX_PEND(MAXP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .refi_limit_i(refi_limit),
        .sr_req_i(sr_req), .ref_gnt_i(gnt), .all_idle_i(idle),
        .ref_req_o(ref_req), .ref_urgent_o(urgent), .pre_all_o(pre_all),
        .cmd_valid_o(cmd_valid), .cs_n_o(cs_n), .ras_n_o(ras_n),
        .cas_n_o(cas_n), .we_n_o(we_n), .cke_o(cke), .bus_free_o(bus_free),
        .read_ok_o(read_ok), .sr_active_o(sr_active), .pending_o(pending)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: pops the expected command kind on every issued command
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            n_cmd++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected command", 1, 0);
            end else begin
                int k;
                int got;
                k   = exp_q.pop_front();
                got = cke ? EXP_AR : EXP_SRE;
                chk(got == k, (k == EXP_AR) ? "R4 kind" : "R6 kind", got, k);
                chk({cs_n, ras_n, cas_n, we_n} == 4'b0001, "R4 pins",
                    int'({cs_n, ras_n, cas_n, we_n}), 1);
                chk(prev_cke == 1'b1, "R4 prior cke", int'(prev_cke), 1);
            end
        end
        prev_cke = cke;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(cke == 1'b1 && ref_req == 1'b0 && pending == 4'd0, "R9 idle", int'(pending), 0);
        chk(bus_free && read_ok && cs_n && ras_n && cas_n && we_n, "R9 flags",
            int'({bus_free, read_ok, cs_n, ras_n, cas_n, we_n}), 63);

        // R1 tick period
        while (pending != 4'd1) @(negedge clk);
        repeat (49) @(negedge clk);
        chk(pending == 4'd1, "R1 before tick", int'(pending), 1);
        @(negedge clk);
        chk(pending == 4'd2, "R1 at tick", int'(pending), 2);

        // R3 request without banks idle: no command
        chk(ref_req && pre_all, "R3 request", int'({ref_req, pre_all}), 3);
        gnt = 1'b1;
        repeat (10) @(negedge clk);
        gnt = 1'b0;
        chk(n_cmd == 0, "R3 no idle no cmd", n_cmd, 0);

        // R2 backlog fills and saturates
        while (pending != 4'd7) @(negedge clk);
        chk(urgent == 1'b0, "R2 not urgent at 7", int'(urgent), 0);
        while (pending != 4'd8) @(negedge clk);
        chk(urgent == 1'b1, "R2 urgent at 8", int'(urgent), 1);
        repeat (120) @(negedge clk);
        chk(pending == 4'd8, "R2 saturate", int'(pending), 8);

        // R4 / R5 single refresh
        refi_limit = 16'd60000;
        exp_q.push_back(EXP_AR);
        gnt  = 1'b1;
        idle = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        chk(cmd_valid == 1'b1, "R4 command cycle", int'(cmd_valid), 1);
        cnt = 0;
        while (!bus_free) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == RFC, "R5 hold length", cnt, RFC);
        chk(pending == 4'd7, "R4 decrement", int'(pending), 7);

        // R4 drain the rest
        repeat (7) exp_q.push_back(EXP_AR);
        gnt = 1'b1;
        while (pending != 4'd0) @(negedge clk);
        repeat (RFC + 2) @(negedge clk);
        gnt = 1'b0;
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R4 drained", exp_q.size(), 0);
        chk(n_cmd == 8, "R4 command count", n_cmd, 8);

        // R10 self-refresh request over a pending refresh
        refi_limit = 16'd30;
        while (pending == 4'd0) @(negedge clk);
        @(negedge clk);
        sr_req = 1'b1;
        @(negedge clk);
        chk(pre_all && ref_req && !cmd_valid, "R10 sr handshake",
            int'({pre_all, ref_req, cmd_valid}), 6);

        // R6 entry
        exp_q.push_back(EXP_SRE);
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        chk(cke == 1'b0 && cmd_valid, "R6 entry cke", int'(cke), 0);
        @(negedge clk);
        chk(sr_active && pending == 4'd0, "R6 active cleared", int'(pending), 0);
        repeat (100) @(negedge clk);
        chk(pending == 4'd0 && cke == 1'b0, "R6 ticks ignored", int'(pending), 0);

        // R7 / R8 exit windows
        sr_req = 1'b0;
        @(negedge clk);
        chk(cke == 1'b1, "R7 cke rises", int'(cke), 1);
        cnt = 0;
        while (!bus_free) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == RFC + 1, "R7 nonread window", cnt, RFC + 1);
        while (!read_ok) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == XSRD, "R8 read window", cnt, XSRD);
        chk(exp_q.size() == 0, "R6 entry seen", exp_q.size(), 0);

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule